// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status

This block holds the interrupt state of a disk controller that has two channels. Each channel has one interrupt flag, and that flag appears in two places in configuration space. The first copy sits in a per-channel status byte. The second copy sits in a shared mode byte. The block keeps the two copies equal at all times. It combines the flags with per-channel blocking bits to drive one level-sensitive interrupt line.

Each channel has a request line, and its edges move the flag. A rising edge sets the flag and a falling edge clears it. Software clears a flag by writing a one to either of its two copies through a dword-addressed configuration port with byte enables. The blocking bits are loaded only through a separate side port. The same read port also returns the channel-enable byte and two fixed identification bytes.

Top module: `irqm_top`

## Requirements
- R1: After reset, all flags and blocking bits are 0 and `irq_level` is 0. Byte 0x09 reads 0x8F and byte 0x3D reads 0x01. Byte 0x51 reads 0x04, or 0x0C when `SEC_EN` is 1 (bit 2 enables channel 0, bit 3 enables channel 1).
- R2: On the first clock edge where `irq_req[c]` is high after being low, channel c's flag becomes 1 in both of its copies. Channel 0's copies are byte 0x50 bit 2 and byte 0x71 bit 2. Channel 1's copies are byte 0x57 bit 4 and byte 0x71 bit 3.
- R3: On the first edge where `irq_req[c]` is low after being high, both copies of channel c's flag become 0.
- R4: The two copies of each channel's flag hold the same value in every cycle.
- R5: A configuration write with the enabled lane carrying a 1 in either copy's flag bit clears both copies on the next edge. Writing a 0 to that bit has no effect.
- R6: Configuration writes do not change any bit of bytes 0x50, 0x57 or 0x71 other than the flag bits. This includes the blocking bits.
- R7: A side-port write loads byte 0x71 bit 4 (which blocks channel 0) from `blk_wdata[0]` and bit 5 (which blocks channel 1) from `blk_wdata[1]`.
- R8: `irq_level` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), as a steady level.
- R9: If a rising request and a clearing write hit the same channel on the same edge, the flag ends set.
- R10: A write lane whose byte enable is 0 has no effect.
- R11: `cfg_rdata` byte lane L returns configuration byte 4*`cfg_addr`+L, combinationally. Undefined bytes read 0.
- R12: A request line that stays high does not set its flag again after the flag has been cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 2 | Per-channel interrupt request levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Dword address |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| blk_we | input | 1 | Side-port write strobe |
| blk_wdata | input | 2 | Blocking bits (bit c blocks channel c) |
| stat_p_byte | output | 8 | Byte 0x50 |
| stat_s_byte | output | 8 | Byte 0x57 |
| mode_byte | output | 8 | Byte 0x71 |
| irq_level | output | 1 | Interrupt line level |

## Verification
The properties assume that the request lines and the write ports are sampled once per clock. They also assume that the request lines are low while reset is held, so that the first edge after reset does not count as a spurious transition. The stimulus changes every input half a cycle before the edge that samples it. It keeps the requests at 0 through reset. It places clearing writes both on their own and on the same edge as request edges, so the set-over-clear rule is exercised without breaking those assumptions.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int CFG_AW = 6;
  localparam int NCH    = 2;

  localparam logic [7:0] OFS_PIF    = 8'h09;
  localparam logic [7:0] OFS_PIN    = 8'h3D;
  localparam logic [7:0] OFS_STAT_P = 8'h50;
  localparam logic [7:0] OFS_EN     = 8'h51;
  localparam logic [7:0] OFS_STAT_S = 8'h57;
  localparam logic [7:0] OFS_MODE   = 8'h71;

  localparam logic [7:0] PIF_VAL = 8'h8F;
  localparam logic [7:0] PIN_VAL = 8'h01;

  // Byte that holds the per-channel (first) copy of a flag
  function automatic logic [7:0] flag_a_ofs(input int ch);
    return (ch == 0) ? OFS_STAT_P : OFS_STAT_S;
  endfunction

  function automatic int flag_a_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

  // Second copy lives in the shared mode byte
  function automatic int flag_b_bit(input int ch);
    return 2 + ch;
  endfunction

  function automatic int blk_bit(input int ch);
    return 4 + ch;
  endfunction

  // True when a write carries a one into bit 'pos' of byte 'ofs'
  function automatic logic write_hits_one(input logic [CFG_AW-1:0] addr,
                                          input logic [3:0] be,
                                          input logic [31:0] wdata,
                                          input logic [7:0] ofs,
                                          input int pos);
    logic [1:0] lane;
    lane = ofs[1:0];
    return (addr == ofs[CFG_AW+1:2]) && be[lane] && wdata[int'(lane)*8 + pos];
  endfunction

  function automatic logic line_level(input logic [NCH-1:0] flags,
                                      input logic [NCH-1:0] blocks);
    return |(flags & ~blocks);
  endfunction

  function automatic logic [7:0] enable_reset(input bit sec);
    return {4'b0000, sec, 1'b1, 2'b00};
  endfunction
endpackage

// File: rtl/irqm_edge.sv
module irqm_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/irqm_flag_cell.sv
module irqm_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic copy_a,
  output logic copy_b
);
  logic nxt;

  // set has priority over any clear source
  always_comb begin
    if (set_i)      nxt = 1'b1;
    else if (clr_i) nxt = 1'b0;
    else            nxt = copy_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_a <= 1'b0;
      copy_b <= 1'b0;
    end else begin
      copy_a <= nxt;
      copy_b <= nxt;
    end
  end
endmodule

// File: rtl/irqm_cfg_read.sv
module irqm_cfg_read
  import irqm_pkg::*;
#(
  parameter int AW = CFG_AW
) (
  input  logic [AW-1:0] addr,
  input  logic [7:0]    stat_p,
  input  logic [7:0]    stat_s,
  input  logic [7:0]    mode,
  input  logic [7:0]    en_byte,
  output logic [31:0]   rdata
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] ofs;
    assign ofs = {addr, 2'(l)};
    always_comb begin
      unique case (ofs)
        OFS_PIF:    rdata[l*8 +: 8] = PIF_VAL;
        OFS_PIN:    rdata[l*8 +: 8] = PIN_VAL;
        OFS_STAT_P: rdata[l*8 +: 8] = stat_p;
        OFS_EN:     rdata[l*8 +: 8] = en_byte;
        OFS_STAT_S: rdata[l*8 +: 8] = stat_s;
        OFS_MODE:   rdata[l*8 +: 8] = mode;
        default:    rdata[l*8 +: 8] = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/irqm_top.sv
module irqm_top
  import irqm_pkg::*;
#(
  parameter bit SEC_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    irq_req,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              blk_we,
  input  logic [NCH-1:0]    blk_wdata,
  output logic [7:0]        stat_p_byte,
  output logic [7:0]        stat_s_byte,
  output logic [7:0]        mode_byte,
  output logic              irq_level
);
  logic [NCH-1:0] req_rise, req_fall;
  logic [NCH-1:0] w1c_hit, flag_a, flag_b;
  logic [NCH-1:0] blk_q;
  logic [7:0]     en_byte;

  irqm_edge #(.W(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(irq_req), .rise(req_rise), .fall(req_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // either copy written with a one clears the pair
    assign w1c_hit[c] = cfg_we &&
      (write_hits_one(cfg_addr, cfg_be, cfg_wdata, flag_a_ofs(c), flag_a_bit(c)) ||
       write_hits_one(cfg_addr, cfg_be, cfg_wdata, OFS_MODE, flag_b_bit(c)));

    irqm_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(req_rise[c]), .clr_i(req_fall[c] | w1c_hit[c]),
      .copy_a(flag_a[c]), .copy_b(flag_b[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_we) blk_q <= blk_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_byte <= enable_reset(SEC_EN);
  end

  always_comb begin
    stat_p_byte = '0;
    stat_s_byte = '0;
    mode_byte   = '0;
    stat_p_byte[flag_a_bit(0)] = flag_a[0];
    stat_s_byte[flag_a_bit(1)] = flag_a[1];
    for (int c = 0; c < NCH; c++) begin
      mode_byte[flag_b_bit(c)] = flag_b[c];
      mode_byte[blk_bit(c)]    = blk_q[c];
    end
  end

  assign irq_level = line_level(flag_b, blk_q);

  irqm_cfg_read #(.AW(CFG_AW)) u_rd (
    .addr(cfg_addr), .stat_p(stat_p_byte), .stat_s(stat_s_byte),
    .mode(mode_byte), .en_byte(en_byte), .rdata(cfg_rdata)
  );
endmodule

// File: rtl/irqm_checker.sv
module irqm_checker
  import irqm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    irq_req,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic              blk_we,
  input logic [NCH-1:0]    blk_wdata,
  input logic [7:0]        stat_p_byte,
  input logic [7:0]        stat_s_byte,
  input logic [7:0]        mode_byte,
  input logic              irq_level
);
  logic clr0_only;
  assign clr0_only = cfg_we && cfg_addr == 6'h14 && cfg_be[0] && cfg_wdata[2];

  assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_p_byte[2] == mode_byte[2]) && (stat_s_byte[4] == mode_byte[3]));

  // also covers R9: a rise wins over a same-edge clear
  assert_rise_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[0] && !$past(irq_req[0])) |=> stat_p_byte[2]);

  assert_fall_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req[1] && $past(irq_req[1])) |=> !stat_s_byte[4]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0_only && !(irq_req[0] && !$past(irq_req[0]))) |=> !mode_byte[2]);

  assert_ro_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_p_byte & 8'hFB) == 8'h00) && ((stat_s_byte & 8'hEF) == 8'h00) &&
    ((mode_byte & 8'hC3) == 8'h00));

  assert_block_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_we |=> (mode_byte[5:4] == $past(blk_wdata)));

  assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == ((stat_p_byte[2] && !mode_byte[4]) || (stat_s_byte[4] && !mode_byte[5])));
endmodule

bind irqm_top irqm_checker u_chk (.*);

// File: tb/tb_irqm_top.sv
module tb_irqm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        blk_we = 1'b0;
  logic [1:0]  blk_wdata = '0;
  logic [31:0] cfg_rdata, rdata_sec;
  logic [7:0]  stat_p_byte, stat_s_byte, mode_byte;
  logic [7:0]  sp2, ss2, mb2;
  logic        irq_level, irq2;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqm_top dut (.*);

  irqm_top #(.SEC_EN(1'b1)) dut_sec (
    .clk(clk), .rst_n(rst_n), .irq_req(2'b00), .cfg_we(1'b0), .cfg_addr(6'h14),
    .cfg_be(4'h0), .cfg_wdata(32'h0), .cfg_rdata(rdata_sec), .blk_we(1'b0),
    .blk_wdata(2'b00), .stat_p_byte(sp2), .stat_s_byte(ss2), .mode_byte(mb2),
    .irq_level(irq2)
  );

  typedef struct {
    logic [7:0] p, s, m;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference state kept from the requirements
  logic [1:0] m_flag = '0, m_blk = '0, m_prev = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, update the model, queue the expected outputs
  task automatic step(input string tag, input logic [1:0] req,
                      input logic we, input logic [5:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input logic bwe, input logic [1:0] bwd);
    exp_t e;
    logic [1:0] clr;
    @(negedge clk);
    irq_req = req; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    blk_we = bwe; blk_wdata = bwd;
    clr[0] = we && ((a == 6'h14 && be[0] && wd[2]) || (a == 6'h1C && be[1] && wd[10]));
    clr[1] = we && ((a == 6'h15 && be[3] && wd[28]) || (a == 6'h1C && be[1] && wd[11]));
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (req[c] && !m_prev[c]) m_flag[c] = 1'b1;
      else if ((!req[c] && m_prev[c]) || clr[c]) m_flag[c] = 1'b0;
    end
    m_prev = req;
    if (bwe) m_blk = bwd;
    e.p = m_flag[0] ? 8'h04 : 8'h00;
    e.s = m_flag[1] ? 8'h10 : 8'h00;
    e.m = {2'b00, m_blk, m_flag, 2'b00};
    e.irq = (m_flag[0] & ~m_blk[0]) | (m_flag[1] & ~m_blk[1]);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " stat_p"}, {24'h0, stat_p_byte}, {24'h0, e.p});
        check({e.tag, " stat_s"}, {24'h0, stat_s_byte}, {24'h0, e.s});
        check({e.tag, " mode"},   {24'h0, mode_byte},   {24'h0, e.m});
        check({e.tag, " irq"},    {31'h0, irq_level},   {31'h0, e.irq});
      end
    end
  end

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_we = 1'b0; blk_we = 1'b0; cfg_addr = a;
    #1 check(tag, cfg_rdata, exp);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset values
    check("R1 stat_p", {24'h0, stat_p_byte}, 32'h0);
    check("R1 mode", {24'h0, mode_byte}, 32'h0);
    check("R1 irq", {31'h0, irq_level}, 32'h0);
    rd("R1 prog-if", 6'h02, 32'h0000_8F00);
    rd("R1 int-pin", 6'h0F, 32'h0000_0100);
    rd("R1 enable", 6'h14, 32'h0000_0400);
    check("R1 enable secondary", rdata_sec, 32'h0000_0C00);

    step("R2 rise ch0", 2'b01, 0, 0, 0, 0, 0, 0);
    step("R2 rise ch1", 2'b11, 0, 0, 0, 0, 0, 0);
    step("R3 fall ch0", 2'b10, 0, 0, 0, 0, 0, 0);
    step("R7 block ch1", 2'b10, 0, 0, 0, 0, 1, 2'b10);
    step("R8 block ch0 only", 2'b10, 0, 0, 0, 0, 1, 2'b01);
    step("R6 mode write ignored", 2'b10, 1, 6'h1C, 4'b0010, 32'h0000_F300, 0, 0);
    step("R6 stat_p write ignored", 2'b10, 1, 6'h14, 4'b0001, 32'h0000_00FB, 0, 0);
    step("R5 w1c via mode", 2'b10, 1, 6'h1C, 4'b0010, 32'h0000_0800, 0, 0);
    step("R12 held request", 2'b10, 0, 0, 0, 0, 0, 0);
    step("R3 fall after clear", 2'b00, 0, 0, 0, 0, 0, 0);
    step("R2 rise ch0 again", 2'b01, 0, 0, 0, 0, 1, 2'b00);
    step("R5 write zero no effect", 2'b01, 1, 6'h14, 4'b0001, 32'hFFFF_FFFB, 0, 0);
    step("R5 w1c via stat_p", 2'b01, 1, 6'h14, 4'b0001, 32'h0000_0004, 0, 0);
    step("R2 rise ch1", 2'b11, 0, 0, 0, 0, 0, 0);
    step("R10 lane masked", 2'b11, 1, 6'h15, 4'b0111, 32'hFFFF_FFFF, 0, 0);
    rd("R11 read 0x57", 6'h15, 32'h1000_0000);
    rd("R11 read 0x71", 6'h1C, 32'h0000_0800);
    step("R5 w1c via stat_s", 2'b11, 1, 6'h15, 4'b1000, 32'h1000_0000, 0, 0);
    step("R3 fall both", 2'b00, 0, 0, 0, 0, 0, 0);
    step("R9 set beats clear", 2'b11, 1, 6'h1C, 4'b0010, 32'h0000_0C00, 0, 0);
    step("R8 block both", 2'b11, 0, 0, 0, 0, 1, 2'b11);
    step("R8 unblock", 2'b11, 0, 0, 0, 0, 1, 2'b00);
    rd("R11 read 0x50", 6'h14, 32'h0000_0404);
    rd("R11 undefined", 6'h30, 32'h0000_0000);
    @(posedge clk); #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule